// File: doc/BRIEF.md
# Programmable SDRAM Bank Address Decoder

This block turns a 32-bit system address into a selection of one of two SDRAM banks, or of no bank at all. Software programs the region through a small register port. One register sets the start of the region on a 32-Mbyte boundary. Two cumulative limit registers close bank 0 and then bank 1. A size register, counted in megabytes, marks the low part of the region that works on a half-width data bus. Address bit 31 must match the start register before any bank can be chosen, so the region never crosses a 2-Gbyte line.

A configuration checker looks at the register values each time a write lands. It raises a sticky error if the limits are out of order, the two banks differ in size, a bank size is not a power of two, the region would cross the 2-Gbyte line, or the half-width part is larger than half of bank 0. While the error is up, every decode reports a miss. A write to the status register runs the check again on the stored values, which clears the error once the programming is legal.

A decode request is an address with a valid strobe. One cycle later the block returns a registered valid, a hit flag, the bank index and the half-width flag.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After synchronous reset, every register reads zero, the status error bit is 0 and rspValid, rspHit, rspBank and rspNarrow are 0.
- R2: Register port, byte offsets. 0x00 is the start register: write data bits [31:25] are stored and read back in bits [31:25], with all other bits 0. 0x04 and 0x08 are the limits of bank 0 and bank 1: a 7-bit value in 32-Mbyte units in bits [6:0]. 0x0C is the half-width size: 11 bits in bits [10:0], in megabytes. 0x10 is status, with the error in bit 0. Reads are combinational from regAddr. Other offsets read 0, and writes to them have no effect.
- R3: rspValid equals reqValid of the previous clock edge. When it is 0, rspHit, rspBank and rspNarrow are 0.
- R4: If address bit 31 differs from start-register bit 31, rspHit is 0.
- R5: Let U be address bits [30:25] and S be start-register bits [30:25]. With bit 31 matching, S <= U < limit0 gives rspHit=1 and rspBank=0.
- R6: With bit 31 matching, limit0 <= U < limit1 gives rspHit=1 and rspBank=1.
- R7: With bit 31 matching, U < S or U >= limit1 gives rspHit=0 and rspBank=0.
- R8: A write to a mapped register other than status sets the error bit if the resulting values break any of these rules: limit0 >= S; limit1 >= limit0; limit1 <= 64; (limit1-limit0) == (limit0-S); the bank size is 0 or a power of two no larger than 32; half-width size <= 16*(limit0-S). The bit then stays set across legal writes. A status write sets the bit to the result of the check on the stored values.
- R9: While the error bit is 1, every decode gives rspHit=0.
- R10: rspNarrow is 1 only when the decode hits, busIs32 is 0, and the address offset from the start of the region, in whole megabytes, is below the half-width size.
- R11: When busIs32 is 1, rspNarrow is 0 and the half-width limit takes no part in the R8 check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| busIs32 | input | 1 | Strap: data bus is full 32-bit |
| reqValid | input | 1 | Decode request valid |
| reqAddr | input | 32 | Address to decode |
| rspValid | output | 1 | Decode result valid |
| rspHit | output | 1 | A bank was selected |
| rspBank | output | 1 | Selected bank index |
| rspNarrow | output | 1 | Access lies in the half-width region |

## Verification
The assertions assume that busIs32 is a strap that only changes while no decode is in flight, and that rst is held for at least one clock edge before use. They also assume that a decode result is judged against the register values and error bit of the cycle in which it was requested. The bench changes the strap and the registers only between decodes, with reqValid low, so every request sees one fixed configuration. Illegal programming is only applied deliberately, to check the error flag and the forced miss.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int REG_AW     = 5;
  localparam int GRAN_LOG2  = 25;
  localparam int MB_LOG2    = 20;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int IDX_W      = ADDR_W - 1 - GRAN_LOG2;
  localparam int UNIT_W     = IDX_W + 1;
  localparam int NSZ_W      = IDX_W + GRAN_LOG2 - MB_LOG2;
  localparam int HALF_SHIFT = GRAN_LOG2 - MB_LOG2 - 1;
  localparam int MAX_UNITS  = 1 << (IDX_W - 1);
  localparam int TOP_UNITS  = 1 << IDX_W;

  localparam logic [REG_AW-1:0] OFF_BASE   = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFF_BND0   = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFF_NARROW = REG_AW'(4 * (NUM_BANKS + 1));
  localparam logic [REG_AW-1:0] OFF_STATUS = REG_AW'(4 * (NUM_BANKS + 2));

  typedef struct packed {
    logic [UNIT_W-1:0]                   baseUnit;
    logic [NUM_BANKS-1:0][UNIT_W-1:0]    bound;
    logic [NSZ_W-1:0]                    narrowMb;
  } cfg_t;

  typedef struct packed {
    logic forceMiss;
    logic narrowEn;
  } strobe_t;

  function automatic logic cfgIllegal(input cfg_t c, input logic bus32);
    logic [UNIT_W-1:0] lo;
    logic [UNIT_W-1:0] sz0;
    logic [UNIT_W-1:0] sz1;
    logic [NSZ_W:0]    halfMb;
    logic              bad;
    lo     = {1'b0, c.baseUnit[IDX_W-1:0]};
    sz0    = c.bound[0] - lo;
    sz1    = c.bound[1] - c.bound[0];
    halfMb = {{(NSZ_W + 1 - UNIT_W){1'b0}}, sz0} << HALF_SHIFT;
    bad    = 1'b0;
    if (c.bound[0] < lo)                        bad = 1'b1;
    if (c.bound[1] < c.bound[0])                bad = 1'b1;
    if (c.bound[1] > UNIT_W'(TOP_UNITS))        bad = 1'b1;
    if (sz0 != sz1)                             bad = 1'b1;
    if ($countones(sz0) > 1)                    bad = 1'b1;
    if (sz0 > UNIT_W'(MAX_UNITS))               bad = 1'b1;
    if (!bus32 && ({1'b0, c.narrowMb} > halfMb)) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/sdram_dec_ctrl.sv
module sdram_dec_ctrl
  import sdram_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busIs32,
  output logic [DATA_W-1:0] regRdData,
  output cfg_t              cfg,
  output strobe_t           strobes,
  output logic              cfgErr
);

  cfg_t cfgQ;
  cfg_t nextCfg;
  logic errQ;
  logic isStatus;
  logic mappedWrite;
  logic illegalNext;
  logic [NUM_BANKS-1:0] hitBound;

  logic unusedWrBits;
  assign unusedWrBits = ^regWrData[GRAN_LOG2-1:NSZ_W];

  genvar g;
  for (g = 0; g < NUM_BANKS; g++) begin : g_bndSel
    assign hitBound[g] = (regAddr == REG_AW'(OFF_BND0 + REG_AW'(4 * g)));
  end

  assign isStatus    = (regAddr == OFF_STATUS);
  assign mappedWrite = regWrEn && (isStatus || (regAddr == OFF_BASE) ||
                                   (regAddr == OFF_NARROW) || (|hitBound));

  always_comb begin
    nextCfg = cfgQ;
    if (regAddr == OFF_BASE)
      nextCfg.baseUnit = regWrData[DATA_W-1:GRAN_LOG2];
    if (regAddr == OFF_NARROW)
      nextCfg.narrowMb = regWrData[NSZ_W-1:0];
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hitBound[i])
        nextCfg.bound[i] = regWrData[UNIT_W-1:0];
    end
  end

  assign illegalNext = cfgIllegal(nextCfg, busIs32);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= '0;
      errQ <= 1'b0;
    end else if (mappedWrite) begin
      cfgQ <= nextCfg;
      errQ <= isStatus ? illegalNext : (errQ | illegalNext);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == OFF_BASE)
      regRdData = {cfgQ.baseUnit, {GRAN_LOG2{1'b0}}};
    else if (regAddr == OFF_NARROW)
      regRdData = {{(DATA_W - NSZ_W){1'b0}}, cfgQ.narrowMb};
    else if (isStatus)
      regRdData = {{(DATA_W - 1){1'b0}}, errQ};
    else begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (hitBound[i])
          regRdData = {{(DATA_W - UNIT_W){1'b0}}, cfgQ.bound[i]};
      end
    end
  end

  assign cfg               = cfgQ;
  assign cfgErr            = errQ;
  assign strobes.forceMiss = errQ;
  assign strobes.narrowEn  = !busIs32;

endmodule

// File: rtl/sdram_dec_path.sv
module sdram_dec_path
  import sdram_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  strobe_t           strobes,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [BANK_W-1:0] rspBank,
  output logic              rspNarrow
);

  logic [UNIT_W-1:0]    addrUnit;
  logic                 topMatch;
  logic [UNIT_W-1:0]    lowB [NUM_BANKS];
  logic [UNIT_W-1:0]    upB  [NUM_BANKS];
  logic [NUM_BANKS-1:0] inRange;
  logic                 hitComb;
  logic [BANK_W-1:0]    bankComb;
  logic [NSZ_W-1:0]     offMb;
  logic                 narrowComb;

  logic unusedAddrBits;
  assign unusedAddrBits = ^reqAddr[MB_LOG2-1:0];

  assign addrUnit = {1'b0, reqAddr[ADDR_W-2:GRAN_LOG2]};
  assign topMatch = (reqAddr[ADDR_W-1] == cfg.baseUnit[UNIT_W-1]);
  assign lowB[0]  = {1'b0, cfg.baseUnit[IDX_W-1:0]};

  genvar g;
  for (g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign upB[g] = cfg.bound[g];
    if (g > 0) begin : g_chain
      assign lowB[g] = upB[g-1];
    end
    assign inRange[g] = topMatch && (addrUnit >= lowB[g]) && (addrUnit < upB[g]);
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    bankComb = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (inRange[i] && !found) begin
        bankComb = BANK_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign hitComb    = (|inRange) && !strobes.forceMiss;
  assign offMb      = {addrUnit[IDX_W-1:0] - cfg.baseUnit[IDX_W-1:0],
                       reqAddr[GRAN_LOG2-1:MB_LOG2]};
  assign narrowComb = hitComb && strobes.narrowEn && (offMb < cfg.narrowMb);

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspBank   <= '0;
      rspNarrow <= 1'b0;
    end else begin
      rspValid  <= reqValid;
      rspHit    <= reqValid && hitComb;
      rspBank   <= (reqValid && hitComb) ? bankComb : '0;
      rspNarrow <= reqValid && narrowComb;
    end
  end

endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
  import sdram_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              busIs32,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [BANK_W-1:0] rspBank,
  output logic              rspNarrow
);

  cfg_t    cfg;
  strobe_t strobes;
  logic    cfgErr;
  logic    baseTop;

  assign baseTop = cfg.baseUnit[UNIT_W-1];

  sdram_dec_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .busIs32   (busIs32),
    .regRdData (regRdData),
    .cfg       (cfg),
    .strobes   (strobes),
    .cfgErr    (cfgErr)
  );

  sdram_dec_path u_path (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .strobes   (strobes),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspBank   (rspBank),
    .rspNarrow (rspNarrow)
  );

endmodule

// File: rtl/sdram_bank_decoder_sva.sv
module sdram_bank_decoder_sva (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic reqTop,
  input logic busIs32,
  input logic rspValid,
  input logic rspHit,
  input logic rspBank,
  input logic rspNarrow,
  input logic cfgErr,
  input logic baseTop
);

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  p_idle_follows_r3: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!rspValid && !rspHit && !rspNarrow));

  p_top_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqTop != baseTop)) |=> !rspHit);

  p_err_forces_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && cfgErr) |=> !rspHit);

  p_narrow_in_bank0_r10: assert property (@(posedge clk) disable iff (rst)
    rspNarrow |-> (rspHit && !rspBank));

  p_strap_blocks_narrow_r11: assert property (@(posedge clk) disable iff (rst)
    busIs32 |=> !rspNarrow);

  p_miss_bank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rspHit |-> !rspBank);

endmodule

bind sdram_bank_decoder sdram_bank_decoder_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqTop    (reqAddr[31]),
  .busIs32   (busIs32),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspBank   (rspBank[0]),
  .rspNarrow (rspNarrow),
  .cfgErr    (cfgErr),
  .baseTop   (baseTop)
);

// File: tb/sdram_bank_decoder_bench.sv
module sdram_bank_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busIs32 = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspHit;
  logic [0:0]  rspBank;
  logic        rspNarrow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_bank_decoder u_sdram_bank_decoder (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busIs32(busIs32),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspBank(rspBank), .rspNarrow(rspNarrow)
  );

  // {addr, hit, bank, narrow, tag}; tag 0:R5 1:R6 2:R7 3:R4
  // start unit 4, limit0 8, limit1 12, half-width 32 MB
  localparam logic [36:0] VEC [10] = '{
    {32'h0800_0000, 1'b1, 1'b0, 1'b1, 2'd0},
    {32'h09FF_FFFF, 1'b1, 1'b0, 1'b1, 2'd0},
    {32'h0A00_0000, 1'b1, 1'b0, 1'b0, 2'd0},
    {32'h0FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0},
    {32'h1000_0000, 1'b1, 1'b1, 1'b0, 2'd1},
    {32'h17FF_FFFF, 1'b1, 1'b1, 1'b0, 2'd1},
    {32'h1800_0000, 1'b0, 1'b0, 1'b0, 2'd2},
    {32'h07FF_FFFF, 1'b0, 1'b0, 1'b0, 2'd2},
    {32'h8800_0000, 1'b0, 1'b0, 1'b0, 2'd3},
    {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd3}
  };

  function automatic string tagName(input logic [1:0] t);
    case (t)
      2'd0:    return "R5";
      2'd1:    return "R6";
      2'd2:    return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic decode(input logic [31:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic legalSetup;
    wr(5'h00, 32'h0800_0000);
    wr(5'h04, 32'd8);
    wr(5'h08, 32'd12);
    wr(5'h10, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 rspValid", {31'b0, rspValid}, 32'd0);
    check("R1 rspHit", {31'b0, rspHit}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(5'(4 * i), v);
      check("R1 register", v, 32'd0);
    end

    // R2 programming and readback
    wr(5'h00, 32'h09FF_FFFF);
    wr(5'h04, 32'hFFFF_FF88);
    wr(5'h08, 32'd12);
    wr(5'h0C, 32'd32);
    rd(5'h00, v); check("R2 start", v, 32'h0800_0000);
    rd(5'h04, v); check("R2 limit0", v, 32'h0000_0008);
    wr(5'h04, 32'd8);
    rd(5'h08, v); check("R2 limit1", v, 32'h0000_000C);
    rd(5'h0C, v); check("R2 narrow", v, 32'h0000_0020);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 status recheck clears", v, 32'd0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); check("R2 unmapped read", v, 32'd0);
    rd(5'h10, v); check("R2 unmapped write ignored", v, 32'd0);
    rd(5'h00, v); check("R2 unmapped write ignored", v, 32'h0800_0000);

    // vector table: R4 R5 R6 R7 R10
    for (int i = 0; i < 10; i++) begin
      decode(VEC[i][36:5]);
      check("R3 valid", {31'b0, rspValid}, 32'd1);
      check(tagName(VEC[i][1:0]), {31'b0, rspHit}, {31'b0, VEC[i][4]});
      check(tagName(VEC[i][1:0]), {31'b0, rspBank}, {31'b0, VEC[i][3]});
      check("R10 narrow", {31'b0, rspNarrow}, {31'b0, VEC[i][2]});
    end

    // R3 idle
    @(negedge clk);
    check("R3 idle valid", {31'b0, rspValid}, 32'd0);
    check("R3 idle hit", {31'b0, rspHit}, 32'd0);

    // R11 strap
    busIs32 = 1'b1;
    decode(32'h0800_0000);
    check("R11 narrow off", {31'b0, rspNarrow}, 32'd0);
    check("R11 still hit", {31'b0, rspHit}, 32'd1);
    wr(5'h0C, 32'd65);
    rd(5'h10, v); check("R11 limit skipped", v, 32'd0);
    busIs32 = 1'b0;
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 half limit", v, 32'd1);
    decode(32'h1000_0000);
    check("R9 forced miss", {31'b0, rspHit}, 32'd0);
    wr(5'h0C, 32'd64);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 exact half legal", v, 32'd0);
    decode(32'h1000_0000);
    check("R6 after clear", {31'b0, rspHit}, 32'd1);
    check("R6 after clear bank", {31'b0, rspBank}, 32'd1);
    decode(32'h0BF0_0000);
    check("R10 offset 63MB", {31'b0, rspNarrow}, 32'd1);

    // R8 unequal sizes and stickiness
    wr(5'h08, 32'd13);
    rd(5'h10, v); check("R8 unequal", v, 32'd1);
    wr(5'h08, 32'd12);
    rd(5'h10, v); check("R8 sticky", v, 32'd1);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 recheck", v, 32'd0);

    // R8 non power of two
    wr(5'h04, 32'd7);
    wr(5'h08, 32'd10);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 size 3", v, 32'd1);
    wr(5'h04, 32'd8);
    wr(5'h08, 32'd12);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 restored", v, 32'd0);

    // R8 crossing the 2-Gbyte line: start 56, limits 60, 64 legal; 72 not
    wr(5'h00, 32'h7000_0000);
    wr(5'h04, 32'd64);
    wr(5'h08, 32'd72);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 beyond 2GB", v, 32'd1);
    legalSetup();

    // R4 start register in upper half
    wr(5'h00, 32'h8800_0000);
    wr(5'h10, 32'd0);
    rd(5'h10, v); check("R8 upper half legal", v, 32'd0);
    decode(32'h8800_0000);
    check("R5 upper half", {31'b0, rspHit}, 32'd1);
    check("R10 upper half", {31'b0, rspNarrow}, 32'd1);
    decode(32'h0800_0000);
    check("R4 lower half miss", {31'b0, rspHit}, 32'd0);

    done = 1'b1;
    finishRun();
  end

endmodule